// File: doc/BRIEF.md
# Boundary-Scan Register with Per-Pin Driver Control

This block is the data register that sits between the test access port's serial input and output when a board-level interconnect test runs. Each bidirectional pad gets three cells: a control cell that decides whether the pad driver is on, a data cell that holds the level to drive, and an observe cell that sees what is on the pad. Input-only strap pads get a single observe cell. The test access port supplies the capture, shift and update strobes and an external-test mode bit; the state machine that makes those strobes is outside this block.

In functional mode the pads follow the core's output-enable and data unchanged. With the external-test bit set, the update latches take over the pad drivers. The shift stages only change the pads through an explicit update strobe, so a pattern can be preloaded and shifted through without disturbing the pads.

Top module: `bsr_chain`

## Requirements
- R1: The chain is 3*NUM_PINS + NUM_STRAPS cells long; a bit entering at `tdi` appears at `tdo` after exactly that many shift cycles.
- R2: After reset, every control cell (shift stage and update latch) holds 1 and every other cell holds 0, so with `extest` high every pad driver is off and `pad_do` is 0.
- R3: On a `capture_dr` cycle, strap cell s (index s) loads `strap_in[s]`; for pin p with base b = NUM_STRAPS + 3p, cell b loads `pad_in[p]`, cell b+1 loads `core_do[p]` and cell b+2 loads the inverse of `core_oe[p]`.
- R4: On each `shift_dr` cycle every cell takes the value of the next higher index, the top cell takes `tdi`, and `tdo` always shows cell 0.
- R5: Update latches change only on an `update_dr` cycle; capture and shift leave `pad_oe` and `pad_do` unchanged in external-test mode.
- R6: With `extest` high, an update strobe makes `pad_do[p]` equal the shifted data bit b+1 and `pad_oe[p]` equal the inverse of control bit b+2.
- R7: With `extest` low, `pad_oe` and `pad_do` equal `core_oe` and `core_do` whatever the latches hold.
- R8: A control latch holding 1 turns the pin's driver off even when its data latch holds 1.
- R9: When `capture_dr` and `shift_dr` are high in the same cycle, the capture is taken and no shift happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all cells act on its rising edge |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data into the highest cell |
| tdo | output | 1 | Serial data from cell 0 |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift enable |
| update_dr | input | 1 | Update strobe |
| extest | input | 1 | External-test mode: latches drive the pads |
| core_oe | input | NUM_PINS | Core output-enable, 1 drives |
| core_do | input | NUM_PINS | Core output data |
| pad_in | input | NUM_PINS | Level seen at each bidirectional pad |
| strap_in | input | NUM_STRAPS | Level seen at each input-only strap pad |
| pad_oe | output | NUM_PINS | Pad driver enable, 1 drives |
| pad_do | output | NUM_PINS | Pad output data |

## Verification
The hardest state to reach from the ports is a set of update latches that differs from the shift stages while the pads are under test control: the pads must hold an earlier pattern while a new one moves through the chain. The stimulus loads one pattern, updates it with external-test mode on, then shifts a second, conflicting pattern all the way in and checks the pads before the second update strobe. The same pattern places a 1 in a data latch under a disabling control bit, and a cycle with capture and shift together is followed by a full unload to show which one won.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;
  localparam int CELLS_PER_PIN = 3;
  localparam int OFS_OBS       = 0;
  localparam int OFS_DATA      = 1;
  localparam int OFS_CTRL      = 2;
  localparam logic CTRL_SAFE   = 1'b1;
  localparam logic DATA_SAFE   = 1'b0;
endpackage

// File: rtl/bsr_rst_sync.sv
`timescale 1ns/1ps
module bsr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/bsr_update_cell.sv
`timescale 1ns/1ps
module bsr_update_cell #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic cap_d,
  input  logic ser_in,
  output logic shift_q,
  output logic upd_q
);
  logic shift_d;
  logic upd_d;

  always_comb begin
    shift_d = shift_q;
    if (capture_en)    shift_d = cap_d;
    else if (shift_en) shift_d = ser_in;
  end

  always_comb begin
    upd_d = upd_q;
    if (update_en) upd_d = shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= RESET_VAL;
      upd_q   <= RESET_VAL;
    end else begin
      shift_q <= shift_d;
      upd_q   <= upd_d;
    end
  end

  AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(upd_q)); // R5
  AST_UPD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> upd_q == $past(shift_q)); // R6
endmodule

// File: rtl/bsr_observe_cell.sv
`timescale 1ns/1ps
module bsr_observe_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_en,
  input  logic shift_en,
  input  logic cap_d,
  input  logic ser_in,
  output logic shift_q
);
  logic shift_d;

  always_comb begin
    shift_d = shift_q;
    if (capture_en)    shift_d = cap_d;
    else if (shift_en) shift_d = ser_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= 1'b0;
    else        shift_q <= shift_d;
  end

  AST_OBS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> shift_q == $past(cap_d)); // R3
endmodule

// File: rtl/bsr_chain.sv
`timescale 1ns/1ps
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int NUM_PINS   = 4,
  parameter int NUM_STRAPS = 1
) (
  input  logic                  tck,
  input  logic                  trst_n,
  input  logic                  tdi,
  output logic                  tdo,
  input  logic                  capture_dr,
  input  logic                  shift_dr,
  input  logic                  update_dr,
  input  logic                  extest,
  input  logic [NUM_PINS-1:0]   core_oe,
  input  logic [NUM_PINS-1:0]   core_do,
  input  logic [NUM_PINS-1:0]   pad_in,
  input  logic [NUM_STRAPS-1:0] strap_in,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_do
);
  localparam int CHAIN_LEN = CELLS_PER_PIN * NUM_PINS + NUM_STRAPS;

  logic                 rst_n;
  logic [CHAIN_LEN-1:0] cell_q;
  logic [CHAIN_LEN-1:0] cell_in;
  logic [NUM_PINS-1:0]  ctrl_upd;
  logic [NUM_PINS-1:0]  data_upd;

  bsr_rst_sync u_rst_sync (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n)
  );

  assign cell_in = {tdi, cell_q[CHAIN_LEN-1:1]};
  assign tdo     = cell_q[0];

  genvar s;
  generate
    for (s = 0; s < NUM_STRAPS; s++) begin : g_strap
      bsr_observe_cell u_obs (
        .clk        (tck),
        .rst_n      (rst_n),
        .capture_en (capture_dr),
        .shift_en   (shift_dr),
        .cap_d      (strap_in[s]),
        .ser_in     (cell_in[s]),
        .shift_q    (cell_q[s])
      );
    end
  endgenerate

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int BASE = NUM_STRAPS + CELLS_PER_PIN * p;

      bsr_observe_cell u_obs (
        .clk        (tck),
        .rst_n      (rst_n),
        .capture_en (capture_dr),
        .shift_en   (shift_dr),
        .cap_d      (pad_in[p]),
        .ser_in     (cell_in[BASE+OFS_OBS]),
        .shift_q    (cell_q[BASE+OFS_OBS])
      );

      bsr_update_cell #(.RESET_VAL(DATA_SAFE)) u_data (
        .clk        (tck),
        .rst_n      (rst_n),
        .capture_en (capture_dr),
        .shift_en   (shift_dr),
        .update_en  (update_dr),
        .cap_d      (core_do[p]),
        .ser_in     (cell_in[BASE+OFS_DATA]),
        .shift_q    (cell_q[BASE+OFS_DATA]),
        .upd_q      (data_upd[p])
      );

      bsr_update_cell #(.RESET_VAL(CTRL_SAFE)) u_ctrl (
        .clk        (tck),
        .rst_n      (rst_n),
        .capture_en (capture_dr),
        .shift_en   (shift_dr),
        .update_en  (update_dr),
        .cap_d      (~core_oe[p]),
        .ser_in     (cell_in[BASE+OFS_CTRL]),
        .shift_q    (cell_q[BASE+OFS_CTRL]),
        .upd_q      (ctrl_upd[p])
      );
    end
  endgenerate

  always_comb begin
    if (extest) begin
      pad_oe = ~ctrl_upd;
      pad_do = data_upd;
    end else begin
      pad_oe = core_oe;
      pad_do = core_do;
    end
  end

  AST_SHIFT_ENTRY: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_dr && !capture_dr) |=> cell_q[CHAIN_LEN-1] == $past(tdi)); // R4
  AST_TDO_ADVANCE: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_dr && !capture_dr) |=> tdo == $past(cell_q[1])); // R4
  AST_PADS_STEADY: assert property (@(posedge tck) disable iff (!rst_n)
    (extest && $past(extest) && !$past(update_dr)) |-> $stable(pad_oe)); // R5
endmodule

// File: tb/test_bsr_chain.sv
`timescale 1ns/1ps
module test_bsr_chain;
  localparam int NP = 4;
  localparam int NS = 1;
  localparam int L  = 3 * NP + NS;

  logic          tck = 1'b0;
  logic          trst_n;
  logic          tdi, capture_dr, shift_dr, update_dr, extest;
  logic [NP-1:0] core_oe, core_do, pad_in;
  logic [NS-1:0] strap_in;
  logic          tdo;
  logic [NP-1:0] pad_oe, pad_do;

  int errors = 0;
  int checks = 0;

  always #2.5 tck = ~tck;

  bsr_chain #(.NUM_PINS(NP), .NUM_STRAPS(NS)) i_bsr_chain (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .extest(extest), .core_oe(core_oe), .core_do(core_do), .pad_in(pad_in),
    .strap_in(strap_in), .pad_oe(pad_oe), .pad_do(pad_do)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] safe_vec();
    logic [L-1:0] v = '0;
    for (int p = 0; p < NP; p++) v[NS + 3*p + 2] = 1'b1;
    return v;
  endfunction

  function automatic logic [L-1:0] cap_vec(input logic [NP-1:0] oe, input logic [NP-1:0] dout,
                                           input logic [NP-1:0] pin, input logic [NS-1:0] st);
    logic [L-1:0] v = '0;
    for (int s = 0; s < NS; s++) v[s] = st[s];
    for (int p = 0; p < NP; p++) begin
      v[NS + 3*p]     = pin[p];
      v[NS + 3*p + 1] = dout[p];
      v[NS + 3*p + 2] = ~oe[p];
    end
    return v;
  endfunction

  function automatic logic [NP-1:0] oe_of(input logic [L-1:0] v);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = ~v[NS + 3*p + 2];
    return r;
  endfunction

  function automatic logic [NP-1:0] do_of(input logic [L-1:0] v);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = v[NS + 3*p + 1];
    return r;
  endfunction

  task automatic shift_chain(input logic [L-1:0] din, output logic [L-1:0] dout);
    for (int i = 0; i < L; i++) begin
      @(negedge tck);
      dout[i]  = tdo;
      tdi      = din[i];
      shift_dr = 1'b1;
    end
    @(negedge tck);
    shift_dr = 1'b0;
    tdi      = 1'b0;
  endtask

  task automatic pulse_capture();
    @(negedge tck); capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge tck); update_dr = 1'b1;
    @(negedge tck); update_dr = 1'b0;
  endtask

  task automatic test_reset();
    logic [L-1:0] got;
    extest = 1'b1;
    @(negedge tck);
    check("R2 pad_oe after reset", pad_oe, '0);
    check("R2 pad_do after reset", pad_do, '0);
    shift_chain('0, got);
    check("R2 shift stages after reset", got, safe_vec());
    extest = 1'b0;
  endtask

  task automatic test_capture(input logic [NP-1:0] oe, input logic [NP-1:0] dout,
                              input logic [NP-1:0] pin, input logic [NS-1:0] st);
    logic [L-1:0] got;
    core_oe = oe; core_do = dout; pad_in = pin; strap_in = st;
    pulse_capture();
    shift_chain('0, got);
    check("R3 captured chain", got, cap_vec(oe, dout, pin, st));
  endtask

  task automatic test_length();
    logic [L-1:0] got;
    logic [L-1:0] pat = 13'h1A5B;
    shift_chain(pat, got);
    shift_chain('0, got);
    check("R1 round trip after L shifts", got, pat);
    shift_chain(13'h0001, got);
    @(negedge tck);
    check("R4 tdo shows cell 0", tdo, 1'b1);
  endtask

  task automatic test_extest_hold();
    logic [L-1:0] got;
    logic [L-1:0] p1;
    logic [L-1:0] p2;
    p1 = '0;
    p1[NS+1] = 1'b1;
    p1[NS+3+2] = 1'b1; p1[NS+3+1] = 1'b1;
    p1[NS+6+1] = 1'b0;
    p1[NS+9+1] = 1'b1;
    p2 = ~p1;
    extest = 1'b1;
    shift_chain(p1, got);
    pulse_update();
    @(negedge tck);
    check("R6 pad_oe from control latches", pad_oe, oe_of(p1));
    check("R6 pad_do from data latches", pad_do, do_of(p1));
    check("R8 disabled pin with data 1", {pad_oe[1], pad_do[1]}, 2'b01);
    shift_chain(p2, got);
    check("R5 pad_oe held during shift", pad_oe, oe_of(p1));
    check("R5 pad_do held during shift", pad_do, do_of(p1));
    pulse_capture();
    check("R5 pad_oe held after capture", pad_oe, oe_of(p1));
    shift_chain(p2, got);
    pulse_update();
    @(negedge tck);
    check("R6 pad_oe after second update", pad_oe, oe_of(p2));
    check("R6 pad_do after second update", pad_do, do_of(p2));
  endtask

  task automatic test_passthrough();
    extest = 1'b0;
    core_oe = 4'b1010; core_do = 4'b0110;
    @(negedge tck);
    check("R7 pad_oe follows core", pad_oe, 4'b1010);
    check("R7 pad_do follows core", pad_do, 4'b0110);
    core_oe = 4'b0101; core_do = 4'b1001;
    @(negedge tck);
    check("R7 pad_oe follows core change", pad_oe, 4'b0101);
    check("R7 pad_do follows core change", pad_do, 4'b1001);
  endtask

  task automatic test_priority();
    logic [L-1:0] got;
    core_oe = 4'b0011; core_do = 4'b1100; pad_in = 4'b1001; strap_in = 1'b1;
    @(negedge tck); capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b0;
    @(negedge tck); capture_dr = 1'b0; shift_dr = 1'b0;
    shift_chain('0, got);
    check("R9 capture wins over shift", got, cap_vec(4'b0011, 4'b1100, 4'b1001, 1'b1));
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    trst_n = 1'b1;
    tdi = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0; extest = 1'b0;
    core_oe = '0; core_do = '0; pad_in = '0; strap_in = '0;
    #1 trst_n = 1'b0;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    repeat (4) @(negedge tck);
    test_reset();
    test_capture(4'b1100, 4'b1010, 4'b0110, 1'b1);
    test_capture(4'b0011, 4'b0101, 4'b1001, 1'b0);
    test_length();
    test_extest_hold();
    test_passthrough();
    test_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule